// File: doc/BRIEF.md
# Microcycle Timing Sequencer

The block produces the timing for each microinstruction of a microcoded processor. It runs on a fast reference clock and divides time into minor-cycle ticks. A tick lasts `TICK_CYC` reference cycles in slow mode and half that many in fast mode. A state-machine clock is high for the first half of each tick. A microinstruction is built from a source phase, an execute phase and, when its destination is slow, one extra closing tick. Each of the two main phases lasts one tick, or two ticks when its stretch option is set.

From this tick frame the block derives several outputs:
- the microinstruction clock, which is aligned to the state-machine clock;
- a source-phase level;
- a one-cycle operand-register clock at the close of the source phase;
- a RAM write enable that stays strictly inside each execute tick;
- a destination write strobe inside the extra tick.

A halt request is examined once per microinstruction, at its end. When it is honoured, the sequencer stops before the next microinstruction clock. A no-op flag cancels the halt. While the sequencer is stopped, a step input runs exactly one tick.

Top module: `ucyc_seq`

## Requirements
- R1: A tick lasts `TICK_CYC` (default 8) reference cycles when `fast_mode` is 0 and `TICK_CYC/2` when it is 1. The mode is sampled at each tick boundary. `sm_clk` is high for the first half of every running tick.
- R2: `uclk` rises in the same cycle as `sm_clk`, at the first tick of each microinstruction, and stays high for half a tick.
- R3: The source phase lasts 2 ticks when `src_double` is 1 and 1 tick otherwise. The execute phase lasts 2 ticks when `exe_double` is 1 and 1 tick otherwise. Both options are sampled at reset and at every microinstruction end.
- R4: `src_stb` is high throughout the source phase. `opnd_clk` is a one-cycle pulse in the last reference cycle of the source phase.
- R5: When `write_req` (sampled at the end of the source phase) is 1, `ram_we` is high in every execute tick from reference cycle 1 through cycle L-2, where L is the tick length. It is low in the first and the last cycle of the tick.
- R6: When `slow_dest` (sampled at the end of the source phase) is 1, one extra tick follows the execute phase. `dest_wr` pulses for one cycle at reference cycle L/2 of that extra tick.
- R7: At the end of a microinstruction, if `halt_req` is 1 and `noop` is 0, the sequencer freezes before the next `uclk`. While frozen, all outputs are low.
- R8: If `noop` is 1 at the end of a microinstruction, the halt request is ignored and the next microinstruction starts in the following cycle.
- R9: While the sequencer is frozen and `halt_req` is 1, a one-cycle `step` pulse runs exactly one tick. The tick starts two cycles after the pulse is driven, and the sequencer freezes again at the end of that tick.
- R10: While the sequencer is frozen, dropping `halt_req` resumes it at the pending tick, two cycles later.
- R11: The synchronous reset `rst` holds all outputs low. In the first cycle after release, the sequencer is at the first tick of a source phase, with `uclk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 1 selects half-length ticks |
| src_double | input | 1 | Source phase takes two ticks |
| exe_double | input | 1 | Execute phase takes two ticks |
| slow_dest | input | 1 | Microinstruction has a slow destination |
| write_req | input | 1 | Microinstruction writes the RAM during execute |
| halt_req | input | 1 | Halt bit of the current microinstruction |
| noop | input | 1 | Current microinstruction is no-oped |
| step | input | 1 | Run one tick while frozen |
| sm_clk | output | 1 | State-machine clock, high in the first half of a tick |
| uclk | output | 1 | Microinstruction clock |
| src_stb | output | 1 | High during the source phase |
| opnd_clk | output | 1 | Operand-register clock pulse at the end of the source phase |
| ram_we | output | 1 | RAM write enable, inside execute ticks |
| dest_wr | output | 1 | Slow-destination write strobe |

## Verification
Every output edge is due at a reference-cycle index that follows from tick length, phase lengths and position within the tick, counted from the first cycle after reset release. The bench computes these indices from the requirements and queues them in order. A monitor then compares each observed edge against the head of the queue in the cycle it occurs, and reports an unexpected edge or an overdue entry. Step and resume requests are scheduled two cycles after they are driven: one cycle for the request register, then the tick starts. The freeze after an honoured halt shows up as the absence of any edge in the following cycles.

// File: rtl/ucyc_pkg.sv
package ucyc_pkg;
  typedef enum logic [1:0] {
    PH_SRC  = 2'd0,
    PH_EXE  = 2'd1,
    PH_XTRA = 2'd2
  } phase_e;
endpackage

// File: rtl/ucyc_tick_gen.sv
// Minor-cycle counter: position within the tick and latched tick length.
module ucyc_tick_gen #(
  parameter int TICK_CYC = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             fast,
  input  logic                             run,
  output logic [$clog2(TICK_CYC+1)-1:0]    pos,
  output logic [$clog2(TICK_CYC+1)-1:0]    len,
  output logic                             tick_last,
  output logic                             sm_clk
);
  localparam int LW = $clog2(TICK_CYC + 1);

  function automatic logic [LW-1:0] len_for(input logic f);
    return f ? LW'(TICK_CYC / 2) : LW'(TICK_CYC);
  endfunction

  logic at_end;
  assign at_end    = (pos == len - 1'b1);
  assign tick_last = run & at_end;
  assign sm_clk    = run & (pos < (len >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      len <= len_for(fast);
    end else if (run) begin
      if (at_end) begin
        pos <= '0;
        len <= len_for(fast);
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ucyc_phase_ctl.sv
// Phase sequencing: source, execute, optional slow-destination tick.
module ucyc_phase_ctl
  import ucyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_last,
  input  logic   src_double,
  input  logic   exe_double,
  input  logic   slow_dest,
  input  logic   write_req,
  output phase_e phase,
  output logic   first_tick,
  output logic   src_end,
  output logic   micro_end,
  output logic   wr_q
);
  logic tidx;
  logic src2, exe2, slow_q;
  logic phase_done;

  always_comb begin
    unique case (phase)
      PH_SRC:  phase_done = (tidx == src2);
      PH_EXE:  phase_done = (tidx == exe2);
      default: phase_done = 1'b1;
    endcase
  end

  assign first_tick = (phase == PH_SRC) & ~tidx;
  assign src_end    = tick_last & phase_done & (phase == PH_SRC);
  assign micro_end  = tick_last & phase_done &
                      ((phase == PH_XTRA) | ((phase == PH_EXE) & ~slow_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_SRC;
      tidx   <= 1'b0;
      src2   <= src_double;
      exe2   <= exe_double;
      slow_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (tick_last) begin
      if (!phase_done) begin
        tidx <= 1'b1;
      end else begin
        tidx <= 1'b0;
        if (src_end) begin
          phase  <= PH_EXE;
          slow_q <= slow_dest;
          wr_q   <= write_req;
        end else if (micro_end) begin
          phase <= PH_SRC;
          src2  <= src_double;
          exe2  <= exe_double;
        end else begin
          phase <= PH_XTRA;
        end
      end
    end
  end
endmodule

// File: rtl/ucyc_halt_ctl.sv
// Freeze at microinstruction end on halt, single-tick stepping, resume.
module ucyc_halt_ctl (
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic noop,
  input  logic step,
  input  logic micro_end,
  input  logic tick_last,
  output logic frozen,
  output logic run
);
  logic halted, stepping;

  assign frozen = halted & ~stepping;
  assign run    = ~frozen;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted   <= 1'b0;
      stepping <= 1'b0;
    end else begin
      if (micro_end)
        halted <= halt_req & ~noop;
      else if (frozen & ~halt_req)
        halted <= 1'b0;

      if (frozen & step & halt_req)
        stepping <= 1'b1;
      else if (tick_last)
        stepping <= 1'b0;
    end
  end
endmodule

// File: rtl/ucyc_strobe_gen.sv
// Output strobes decoded from phase and position in the tick.
module ucyc_strobe_gen
  import ucyc_pkg::*;
#(
  parameter int TICK_CYC = 8,
  parameter int WE_LEAD  = 1,
  parameter int WE_TAIL  = 1
) (
  input  logic                          run,
  input  logic [$clog2(TICK_CYC+1)-1:0] pos,
  input  logic [$clog2(TICK_CYC+1)-1:0] len,
  input  phase_e                        phase,
  input  logic                          first_tick,
  input  logic                          src_end,
  input  logic                          wr_q,
  output logic                          uclk,
  output logic                          src_stb,
  output logic                          opnd_clk,
  output logic                          ram_we,
  output logic                          dest_wr
);
  localparam int LW = $clog2(TICK_CYC + 1);

  function automatic logic in_we_window(input logic [LW-1:0] p, input logic [LW-1:0] l);
    return (p >= LW'(WE_LEAD)) && (p <= l - LW'(WE_TAIL + 1));
  endfunction

  function automatic logic at_mid(input logic [LW-1:0] p, input logic [LW-1:0] l);
    return p == (l >> 1);
  endfunction

  assign uclk     = run & first_tick & (pos < (len >> 1));
  assign src_stb  = run & (phase == PH_SRC);
  assign opnd_clk = src_end;
  assign ram_we   = run & (phase == PH_EXE) & wr_q & in_we_window(pos, len);
  assign dest_wr  = run & (phase == PH_XTRA) & at_mid(pos, len);
endmodule

// File: rtl/ucyc_seq.sv
module ucyc_seq
  import ucyc_pkg::*;
#(
  parameter int TICK_CYC = 8,
  parameter int WE_LEAD  = 1,
  parameter int WE_TAIL  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  input  logic src_double,
  input  logic exe_double,
  input  logic slow_dest,
  input  logic write_req,
  input  logic halt_req,
  input  logic noop,
  input  logic step,
  output logic sm_clk,
  output logic uclk,
  output logic src_stb,
  output logic opnd_clk,
  output logic ram_we,
  output logic dest_wr
);
  localparam int LW = $clog2(TICK_CYC + 1);

  logic [LW-1:0] pos, len;
  logic          tick_last, sm_clk_i;
  logic          run, frozen;
  phase_e        phase;
  logic          first_tick, src_end, micro_end, wr_q;
  logic          uclk_i, src_i, opnd_i, we_i, dw_i;

  ucyc_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst(rst), .fast(fast_mode), .run(run),
    .pos(pos), .len(len), .tick_last(tick_last), .sm_clk(sm_clk_i)
  );

  ucyc_phase_ctl u_phase (
    .clk(clk), .rst(rst), .tick_last(tick_last),
    .src_double(src_double), .exe_double(exe_double),
    .slow_dest(slow_dest), .write_req(write_req),
    .phase(phase), .first_tick(first_tick), .src_end(src_end),
    .micro_end(micro_end), .wr_q(wr_q)
  );

  ucyc_halt_ctl u_halt (
    .clk(clk), .rst(rst), .halt_req(halt_req), .noop(noop), .step(step),
    .micro_end(micro_end), .tick_last(tick_last),
    .frozen(frozen), .run(run)
  );

  ucyc_strobe_gen #(.TICK_CYC(TICK_CYC), .WE_LEAD(WE_LEAD), .WE_TAIL(WE_TAIL)) u_strb (
    .run(run), .pos(pos), .len(len), .phase(phase), .first_tick(first_tick),
    .src_end(src_end), .wr_q(wr_q),
    .uclk(uclk_i), .src_stb(src_i), .opnd_clk(opnd_i), .ram_we(we_i), .dest_wr(dw_i)
  );

  assign sm_clk   = sm_clk_i & ~rst;
  assign uclk     = uclk_i   & ~rst;
  assign src_stb  = src_i    & ~rst;
  assign opnd_clk = opnd_i   & ~rst;
  assign ram_we   = we_i     & ~rst;
  assign dest_wr  = dw_i     & ~rst;
endmodule

// File: rtl/ucyc_seq_chk.sv
module ucyc_seq_chk (
  input logic clk,
  input logic rst,
  input logic halt_req,
  input logic noop,
  input logic step,
  input logic sm_clk,
  input logic uclk,
  input logic src_stb,
  input logic opnd_clk,
  input logic ram_we,
  input logic dest_wr,
  input logic frozen,
  input logic micro_end,
  input logic tick_last
);
  a_r2_uclk_with_smclk: assert property (@(posedge clk) disable iff (rst)
    $rose(uclk) |-> $rose(sm_clk));

  a_r4_src_closes: assert property (@(posedge clk) disable iff (rst)
    opnd_clk |=> !src_stb);

  a_r5_we_off_at_tick_end: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !tick_last);

  a_r5_we_off_at_tick_start: assert property (@(posedge clk) disable iff (rst)
    $rose(sm_clk) |-> !ram_we);

  a_r6_dest_wr_single: assert property (@(posedge clk) disable iff (rst)
    dest_wr |=> !dest_wr);

  a_r7_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    (micro_end && halt_req && !noop) |=> (!sm_clk && !uclk));

  a_r8_noop_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (micro_end && noop) |=> uclk);

  a_r9_step_starts_tick: assert property (@(posedge clk) disable iff (rst)
    (frozen && step && halt_req) |=> sm_clk);

  a_r11_restart_at_source: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (uclk && src_stb));
endmodule

bind ucyc_seq ucyc_seq_chk u_chk (
  .clk(clk), .rst(rst), .halt_req(halt_req), .noop(noop), .step(step),
  .sm_clk(sm_clk), .uclk(uclk), .src_stb(src_stb), .opnd_clk(opnd_clk),
  .ram_we(ram_we), .dest_wr(dest_wr), .frozen(frozen),
  .micro_end(micro_end), .tick_last(tick_last)
);

// File: tb/ucyc_seq_test.sv
`timescale 1ns/1ps
module ucyc_seq_test;
  localparam int TICK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_mode = 0, src_double = 0, exe_double = 0, slow_dest = 0;
  logic write_req = 0, halt_req = 0, noop = 0, step = 0;
  logic sm_clk, uclk, src_stb, opnd_clk, ram_we, dest_wr;

  always #10 clk = ~clk;

  ucyc_seq #(.TICK_CYC(TICK)) uut (
    .clk(clk), .rst(rst), .fast_mode(fast_mode), .src_double(src_double),
    .exe_double(exe_double), .slow_dest(slow_dest), .write_req(write_req),
    .halt_req(halt_req), .noop(noop), .step(step),
    .sm_clk(sm_clk), .uclk(uclk), .src_stb(src_stb), .opnd_clk(opnd_clk),
    .ram_we(ram_we), .dest_wr(dest_wr)
  );

  typedef struct {
    int    s;
    int    k;
    string r;
  } ev_t;

  ev_t   q[$];
  int    errs = 0, chks = 0;
  int    g = -1;
  int    lim = 1000000;
  string ctx = "";
  logic  p_sm = 0, p_uc = 0, p_src = 0, p_we = 0;

  // Event kinds: 0 sm_clk rise, 1 uclk rise, 2 src_stb rise, 3 opnd_clk,
  // 4 ram_we rise, 5 ram_we fall, 6 dest_wr
  function automatic string kreq(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2, 3: return "R4";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_ticks(int start, int L, int S, int E, int X, int W, int tf, int tt);
    for (int t = tf; t <= tt; t++) begin
      for (int p = 0; p < L; p++) begin
        int s = start + (t - tf) * L + p;
        bit ex = (t >= S) && (t < S + E);
        if (p == 0) q.push_back('{s, 0, {kreq(0), "/", ctx}});
        if (t == 0 && p == 0) q.push_back('{s, 1, {kreq(1), "/", ctx}});
        if (t == 0 && p == 0) q.push_back('{s, 2, {kreq(2), "/", ctx}});
        if (t == S - 1 && p == L - 1) q.push_back('{s, 3, {"R3/R4/", ctx}});
        if (W != 0 && ex && p == 1) q.push_back('{s, 4, {kreq(4), "/", ctx}});
        if (W != 0 && ex && p == L - 1) q.push_back('{s, 5, {kreq(5), "/", ctx}});
        if (X != 0 && t == S + E && p == L / 2) q.push_back('{s, 6, {kreq(6), "/", ctx}});
      end
    end
  endtask

  // Monitor: compare observed edges against the expected queue
  always @(negedge clk) begin
    if (rst) begin
      g = -1;
      p_sm = 0; p_uc = 0; p_src = 0; p_we = 0;
    end else begin
      g++;
      if (g <= lim) begin
        bit [6:0] cur;
        cur[0] = sm_clk & ~p_sm;
        cur[1] = uclk & ~p_uc;
        cur[2] = src_stb & ~p_src;
        cur[3] = opnd_clk;
        cur[4] = ram_we & ~p_we;
        cur[5] = ~ram_we & p_we;
        cur[6] = dest_wr;
        for (int kd = 0; kd < 7; kd++) begin
          if (cur[kd]) begin
            if (q.size() > 0 && q[0].s == g && q[0].k == kd) begin
              chk(1'b1, q[0].r, "edge", g, g);
              void'(q.pop_front());
            end else begin
              chk(1'b0, {kreq(kd), "/", ctx}, $sformatf("unexpected edge kind %0d", kd),
                  g, (q.size() > 0) ? q[0].s : -1);
            end
          end
        end
        while (q.size() > 0 && q[0].s < g) begin
          chk(1'b0, q[0].r, $sformatf("missing edge kind %0d", q[0].k), -1, q[0].s);
          void'(q.pop_front());
        end
      end
      p_sm = sm_clk; p_uc = uclk; p_src = src_stb; p_we = ram_we;
    end
  end

  task automatic begin_run(bit f, bit sd, bit ed, bit sl, bit wr, bit hr, string c);
    rst = 1'b1;
    fast_mode = f; src_double = sd; exe_double = ed; slow_dest = sl;
    write_req = wr; halt_req = hr; noop = 1'b0; step = 1'b0;
    ctx = c;
    lim = 1000000;
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: all outputs low while reset is held
    chk({sm_clk, uclk, src_stb, opnd_clk, ram_we, dest_wr} == 6'b0, "R11", "outputs in reset",
        int'({sm_clk, uclk, src_stb, opnd_clk, ram_we, dest_wr}), 0);
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic end_run(int n);
    repeat (n) @(negedge clk);
    #1;
    while (q.size() > 0) begin
      chk(1'b0, q[0].r, $sformatf("never seen edge kind %0d", q[0].k), -1, q[0].s);
      void'(q.pop_front());
    end
  endtask

  task automatic do_step(int L, int S, int E, int X, int W, int t, output int s0);
    @(negedge clk);
    #1 s0 = g + 2;
    push_ticks(s0, L, S, E, X, W, t, t);
    @(posedge clk);
    #1 step = 1'b1;
    @(posedge clk);
    #1 step = 1'b0;
    repeat (L + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, chks + 1);
    $finish;
  end

  initial begin
    int s0;
    int s1;

    // A: slow ticks, single-tick phases, no writes (R1 R2 R3 R4 R11)
    begin_run(0, 0, 0, 0, 0, 0, "A-slow-R11");
    lim = 3 * 16 - 1;
    for (int m = 0; m < 3; m++) push_ticks(m * 16, TICK, 1, 1, 0, 0, 0, 1);
    end_run(52);

    // B: fast ticks, both phases doubled, writes and slow destination (R3 R5 R6)
    begin_run(1, 1, 1, 1, 1, 0, "B-fast-R3");
    lim = 3 * 20 - 1;
    for (int m = 0; m < 3; m++) push_ticks(m * 20, TICK / 2, 2, 2, 1, 1, 0, 4);
    end_run(64);

    // C: slow ticks, doubled execute with back-to-back writes (R5)
    begin_run(0, 0, 1, 0, 1, 0, "C-wr-R5");
    lim = 2 * 24 - 1;
    for (int m = 0; m < 2; m++) push_ticks(m * 24, TICK, 1, 2, 0, 1, 0, 2);
    end_run(52);

    // D: halt freezes after first microinstruction (R7), step (R9), resume (R10)
    begin_run(1, 0, 0, 1, 1, 1, "D-halt-R7");
    push_ticks(0, 4, 1, 1, 1, 1, 0, 2);
    repeat (40) @(negedge clk);
    ctx = "D-step-R9";
    do_step(4, 1, 1, 1, 1, 0, s0);
    repeat (10) @(negedge clk);
    do_step(4, 1, 1, 1, 1, 1, s0);
    ctx = "D-resume-R10";
    @(negedge clk);
    #1 s0 = g + 2;
    push_ticks(s0, 4, 1, 1, 1, 1, 2, 2);
    push_ticks(s0 + 4, 4, 1, 1, 1, 1, 0, 2);
    lim = s0 + 4 + 11;
    @(posedge clk);
    #1 halt_req = 1'b0;
    end_run(24);

    // E: no-op cancels the halt bit at microinstruction end (R8)
    begin_run(1, 0, 0, 1, 1, 1, "E-noop-R8");
    push_ticks(0, 4, 1, 1, 1, 1, 0, 2);
    repeat (30) @(negedge clk);
    #1 noop = 1'b1;
    do_step(4, 1, 1, 1, 1, 0, s1);
    do_step(4, 1, 1, 1, 1, 1, s1);
    @(negedge clk);
    #1 s1 = g + 2;
    push_ticks(s1, 4, 1, 1, 1, 1, 2, 2);
    push_ticks(s1 + 4, 4, 1, 1, 1, 1, 0, 2);
    lim = s1 + 4 + 11;
    @(posedge clk);
    #1 step = 1'b1;
    @(posedge clk);
    #1 step = 1'b0;
    end_run(24);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule